// File: doc/BRIEF.md
# Stop-Mode Clock Wake Controller

This block governs a full clock halt for a small processor and the orderly return from it. Software writes a one to the halt bit of the control register, and the bus clock enable drops on the next edge. While halted, the block watches a pending-interrupt line. When that line is seen high, the halt bit clears and an oscillator settling interval begins. A down-counter loaded from a parameter stands in for the analog oscillator.

When the settling interval ends, the bus clock enable returns. For that one cycle a wake-done strobe is raised, so the interrupt entry logic knows it may start. At the same edge the active divide ratio is fixed as follows. If the main clock feeds the bus, the ratio is forced to divide-by-8. If the sub-clock feeds the bus, the ratio software last stored is kept.

The register port has two targets, chosen by a select bit: the control register and the divide-ratio register. Both accept writes only while the bus clock runs.

Top module: `clk_wake_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `bclk_en` is 1, `wake_done` is 0 and `div_act` holds code 3. The divide code is the log2 of the ratio, so 3 means divide-by-8.
- R2: While running, a write with `reg_sel`=0 and `reg_wdata[0]`=1 makes `bclk_en` 0 after that edge. A write with `reg_sel`=0 and `reg_wdata[0]`=0 changes nothing.
- R3: While halted, the first edge that samples `irq_pend` high starts the settling wait. `bclk_en` stays 0 until exactly `START_CNT` edges after that edge, and then becomes 1.
- R4: `wake_done` is 1 for exactly one cycle: the first cycle in which `bclk_en` is 1 again after a halt.
- R5: If `src_sub` is 0 at the wake edge, `div_act` becomes code 3 at that edge.
- R6: If `src_sub` is 1 at the wake edge, `div_act` keeps the value it held before the halt.
- R7: While running, a write with `reg_sel`=1 loads `reg_wdata` into `div_act` on that edge.
- R8: Writes of either kind are ignored while halted or settling.
- R9: If `irq_pend` is already high when the halt write occurs, the block still halts. It then wakes through the full `START_CNT` wait, so `bclk_en` returns `START_CNT`+1 edges after the halt-write edge.
- R10: `irq_pend` has no effect while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (keeps running while the bus clock is halted) |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 selects control (bit 0 = halt), 1 selects divide ratio |
| reg_wdata | input | DIV_W | Write data |
| irq_pend | input | 1 | An enabled interrupt request is pending |
| src_sub | input | 1 | Bus clock source: 0 = main clock, 1 = sub-clock |
| bclk_en | output | 1 | Registered bus clock enable |
| div_act | output | DIV_W | Active main divide code (log2 of the ratio) |
| wake_done | output | 1 | One-cycle strobe on the first bus cycle after wake |

## Verification
The bench builds the block with `START_CNT`=5 and `DIV_W`=3. This keeps each settling interval short enough to sweep every combination of the following:
- all eight stored divide codes;
- both clock sources;
- four arrival points for the interrupt, including one already pending at the halt write.

For every combination the bench counts the edges until the enable returns and compares the divide code against the value the source rule predicts. The same sweep also places a divide write inside the halt, to show that it is dropped.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WARM = 2'd2
  } cwc_state_e;
endpackage

// File: rtl/cwc_startup_timer.sv
module cwc_startup_timer #(
  parameter int START_CNT = 1024,
  parameter int CNT_W     = $clog2(START_CNT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic tick,
  output logic last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= CNT_W'(START_CNT);
    else if (tick && cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cwc_ctrl_fsm.sv
module cwc_ctrl_fsm
  import cwc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic irq_pend,
  input  logic tmr_last,
  output logic tmr_load,
  output logic tmr_tick,
  output logic wake_now,
  output logic bclk_en_q,
  output logic wake_q
);
  cwc_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_tick = 1'b0;
    wake_now = 1'b0;
    case (state_q)
      ST_RUN:  if (halt_req) state_d = ST_HALT;
      ST_HALT: if (irq_pend) begin
                 state_d  = ST_WARM;
                 tmr_load = 1'b1;
               end
      ST_WARM: begin
                 tmr_tick = 1'b1;
                 if (tmr_last) begin
                   state_d  = ST_RUN;
                   wake_now = 1'b1;
                 end
               end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      bclk_en_q <= 1'b1;
      wake_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      bclk_en_q <= (state_d == ST_RUN);
      wake_q    <= wake_now;
    end
  end
endmodule

// File: rtl/cwc_div_reg.sv
module cwc_div_reg #(
  parameter int DIV_W     = 3,
  parameter int DIV8_CODE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_val,
  input  logic             wake,
  input  logic             src_sub,
  output logic [DIV_W-1:0] div_q
);
  localparam logic [DIV_W-1:0] SLOW_CODE = DIV_W'(DIV8_CODE);

  always_ff @(posedge clk) begin
    if (rst)
      div_q <= SLOW_CODE;
    else if (wake && !src_sub)
      div_q <= SLOW_CODE;
    else if (wr_en)
      div_q <= wr_val;
  end
endmodule

// File: rtl/clk_wake_ctrl.sv
module clk_wake_ctrl #(
  parameter int START_CNT = 1024,
  parameter int DIV_W     = 3,
  parameter int DIV8_CODE = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [DIV_W-1:0] reg_wdata,
  input  logic             irq_pend,
  input  logic             src_sub,
  output logic             bclk_en,
  output logic [DIV_W-1:0] div_act,
  output logic             wake_done
);
  localparam int CNT_W = $clog2(START_CNT + 1);

  logic halt_req, div_wr;
  logic tmr_load, tmr_tick, tmr_last, wake_now;

  // Register writes only land while the bus clock is running.
  assign halt_req = bclk_en && reg_we && !reg_sel && reg_wdata[0];
  assign div_wr   = bclk_en && reg_we && reg_sel;

  cwc_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .halt_req  (halt_req),
    .irq_pend  (irq_pend),
    .tmr_last  (tmr_last),
    .tmr_load  (tmr_load),
    .tmr_tick  (tmr_tick),
    .wake_now  (wake_now),
    .bclk_en_q (bclk_en),
    .wake_q    (wake_done)
  );

  cwc_startup_timer #(.START_CNT(START_CNT), .CNT_W(CNT_W)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .tick (tmr_tick),
    .last (tmr_last)
  );

  cwc_div_reg #(.DIV_W(DIV_W), .DIV8_CODE(DIV8_CODE)) u_div (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (div_wr),
    .wr_val  (reg_wdata),
    .wake    (wake_now),
    .src_sub (src_sub),
    .div_q   (div_act)
  );
endmodule

// File: rtl/cwc_checker.sv
module cwc_checker #(
  parameter int DIV_W     = 3,
  parameter int DIV8_CODE = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic             reg_sel,
  input logic [DIV_W-1:0] reg_wdata,
  input logic             src_sub,
  input logic             bclk_en,
  input logic [DIV_W-1:0] div_act,
  input logic             wake_done
);
  localparam logic [DIV_W-1:0] SLOW_CODE = DIV_W'(DIV8_CODE);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (bclk_en && !wake_done && div_act == SLOW_CODE));

  a_r2_halt_drops_enable: assert property (@(posedge clk) disable iff (rst)
    (bclk_en && reg_we && !reg_sel && reg_wdata[0]) |=> !bclk_en);

  a_r3_enable_returns_with_strobe: assert property (@(posedge clk) disable iff (rst)
    (bclk_en && !$past(bclk_en)) |-> wake_done);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_done |=> !wake_done);

  a_r4_on_first_cycle: assert property (@(posedge clk) disable iff (rst)
    wake_done |-> (bclk_en && !$past(bclk_en)));

  a_r5_main_forces_slow: assert property (@(posedge clk) disable iff (rst)
    (wake_done && !$past(src_sub)) |-> (div_act == SLOW_CODE));

  a_r6_sub_keeps_ratio: assert property (@(posedge clk) disable iff (rst)
    (wake_done && $past(src_sub)) |-> $stable(div_act));

  a_r7_div_write: assert property (@(posedge clk) disable iff (rst)
    (bclk_en && reg_we && reg_sel) |=> (div_act == $past(reg_wdata)));

  a_r8_frozen_while_halted: assert property (@(posedge clk) disable iff (rst)
    !bclk_en |=> ($stable(div_act) || wake_done));

  a_r10_runs_without_halt: assert property (@(posedge clk) disable iff (rst)
    (bclk_en && !(reg_we && !reg_sel && reg_wdata[0])) |=> bclk_en);
endmodule

bind clk_wake_ctrl cwc_checker #(.DIV_W(DIV_W), .DIV8_CODE(DIV8_CODE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .src_sub   (src_sub),
  .bclk_en   (bclk_en),
  .div_act   (div_act),
  .wake_done (wake_done)
);

// File: tb/clk_wake_ctrl_bench.sv
module clk_wake_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int START      = 5;
  localparam int DW         = 3;
  localparam int SLOW       = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0, reg_sel = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic          irq_pend = 1'b0, src_sub = 1'b0;
  logic          bclk_en, wake_done;
  logic [DW-1:0] div_act;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  clk_wake_ctrl #(.START_CNT(START), .DIV_W(DW), .DIV8_CODE(SLOW)) u_clk_wake_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .irq_pend(irq_pend), .src_sub(src_sub), .bclk_en(bclk_en), .div_act(div_act),
    .wake_done(wake_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [DW-1:0] data);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int exp_div;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bclk_en == 1'b1, "R1 enable in reset", int'(bclk_en), 1);
    chk(div_act == DW'(SLOW), "R1 divide in reset", int'(div_act), SLOW);
    rst = 1'b0;
    step();
    chk(bclk_en == 1'b1 && wake_done == 1'b0, "R1 after reset", int'(bclk_en), 1);
    chk(div_act == DW'(SLOW), "R1 divide after reset", int'(div_act), SLOW);

    // R10: pending interrupt while running
    irq_pend = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(bclk_en == 1'b1 && wake_done == 1'b0, "R10 irq while running", int'(bclk_en), 1);
    end
    irq_pend = 1'b0;

    // R2: control write with bit 0 clear does nothing
    wr(1'b0, DW'(6));
    chk(bclk_en == 1'b1, "R2 zero halt bit", int'(bclk_en), 1);
    chk(div_act == DW'(SLOW), "R2 zero halt bit divide", int'(div_act), SLOW);

    for (int src = 0; src < 2; src++) begin
      for (int d = 0; d < 8; d++) begin
        for (int dly = 0; dly < 4; dly++) begin
          wr(1'b1, DW'(d));
          chk(div_act == DW'(d), "R7 divide write", int'(div_act), d);
          src_sub = src[0];
          if (dly == 0) irq_pend = 1'b1;
          wr(1'b0, DW'(1));
          chk(bclk_en == 1'b0, (dly == 0) ? "R9 halt with irq pending" : "R2 halt entry",
              int'(bclk_en), 0);
          if (dly > 0) begin
            for (int k = 0; k < dly; k++) begin
              if (k == 1) wr(1'b1, ~DW'(d));
              else step();
              chk(bclk_en == 1'b0, "R8 stays halted", int'(bclk_en), 0);
            end
            irq_pend = 1'b1;
          end
          n = 0;
          for (int k = 1; k <= START + 6; k++) begin
            step();
            n = k;
            if (bclk_en) break;
            chk(wake_done == 1'b0, "R4 no strobe while halted", int'(wake_done), 0);
          end
          chk(n == START + 1, (dly == 0) ? "R9 full wait" : "R3 wake latency", n, START + 1);
          chk(wake_done == 1'b1, "R4 strobe on wake", int'(wake_done), 1);
          exp_div = (src == 1) ? d : SLOW;
          chk(div_act == DW'(exp_div), (src == 1) ? "R6 sub keeps ratio" : "R5 main forces slow",
              int'(div_act), exp_div);
          if (src == 1 && dly > 1)
            chk(div_act == DW'(d), "R8 write during halt dropped", int'(div_act), d);
          irq_pend = 1'b0;
          step();
          chk(wake_done == 1'b0, "R4 strobe one cycle", int'(wake_done), 0);
          chk(bclk_en == 1'b1, "R3 stays running", int'(bclk_en), 1);
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule